// File: doc/BRIEF.md
# DDR Memory Power-Up Command Sequencer

This block brings an external DDR1 or DDR2 SDRAM device from its post-reset state into a usable operating state. A single start pulse launches the sequence. The block then emits a fixed, ordered list of device commands: precharge-all, auto-refresh, and loads of the mode register and the extended mode registers. Each command appears as a one-cycle strobe together with a one-hot command code, a target-register select and the value to load. A fixed number of idle clock cycles separates consecutive commands.

Two strap inputs shape the run, and the block captures both only at the moment the start pulse is accepted. The first strap picks the DDR2 path or the DDR1 path. The DDR2 path is longer and includes an on-chip driver calibration default load followed by a calibration exit load. The second strap tells the block whether the reference clock is 40 MHz or 25 MHz, and this choice fixes the refresh interval handed to the external refresh engine.

When DDR2 is selected, a DDR2 configuration word is presented before the first command. After the last command, the block publishes the refresh control word, initial delay values for both strobe-capture taps, and a read-cycle mask. At the same time it raises a done flag, which stays high until reset.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, every output is zero, busy_o and done_o included.
- R2: A start_i sampled high in the idle state starts the sequence. busy_o rises, and the first command strobe is high in the cycle right after that sampling edge.
- R3: cmd_valid_o is high for exactly one clock per command. Consecutive strobes are exactly GAP_CYCLES+1 clock edges apart (default GAP_CYCLES = 8). Outside a strobe, cmd_code_o, reg_sel_o and mode_data_o are zero.
- R4: cmd_code_o is one-hot during a strobe. Bit 0 loads the mode register, bit 1 the extended register, bit 2 is auto-refresh, bit 3 is precharge-all, bit 4 loads extended register 2, and bit 5 loads extended register 3. reg_sel_o is 0/1/2/3 for mode/extended/extended-2/extended-3, and reg_sel_o and mode_data_o are 0 for precharge and auto-refresh.
- R5: The DDR2 path issues 11 commands in this order: precharge; ext-2 load 0; ext-3 load 0; ext load 0; mode load 0x100; precharge; auto-refresh; auto-refresh; mode load 0xA33; ext load 0x382; ext load 0x402.
- R6: The DDR1 path issues 5 commands in this order: precharge; mode load 0x133; ext load 0x002; precharge; mode load 0x033.
- R7: On the DDR2 path, ddr2_cfg_o equals 0xA59 from the first strobe cycle onward. Its fields are write latency 2 in bits [13:10], ODT enable in bit 9, tFAW 22 in bits [7:2] and enable in bit 0. On the DDR1 path it stays zero.
- R8: From the done cycle on, refresh_o equals bit 14 set ORed with a 10-bit count in bits [9:0]: 624 (0x4270) with the 40 MHz strap, 390 (0x4186) otherwise. Before done it is zero.
- R9: From the done cycle on, dqs_tap0_o = 0x08, dqs_tap1_o = 0x09 and rd_mask_o = 0xFF. Before done all three are zero.
- R10: done_o rises, and busy_o falls, GAP_CYCLES+1 edges after the last strobe. done_o then stays high until reset, and no further strobes occur.
- R11: start_i is ignored while busy and after done. It produces no extra strobe and no restart of the command list.
- R12: Strap changes after the start pulse has been accepted have no effect on the command list, the configuration word or the refresh value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that launches the sequence |
| strap_ddr2_i | input | 1 | 1 = DDR2 path, 0 = DDR1 path |
| strap_ref40_i | input | 1 | 1 = 40 MHz reference, 0 = 25 MHz |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 6 | One-hot command code |
| reg_sel_o | output | 2 | Target register of a load |
| mode_data_o | output | 13 | Value to load into the selected register |
| ddr2_cfg_o | output | 16 | DDR2 configuration word |
| refresh_o | output | 16 | Refresh enable and interval count |
| dqs_tap0_o | output | 6 | Initial delay tap, strobe lane 0 |
| dqs_tap1_o | output | 6 | Initial delay tap, strobe lane 1 |
| rd_mask_o | output | 8 | Read-cycle mask |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (sticky until reset) |

## Verification
The assertions assume that reset is applied before any use. They also assume that start_i and the straps are driven synchronously to clk, which lets the strap capture and the spacing between strobes be checked cycle by cycle. The bench changes every input only on the falling clock edge. It resets the block before each scenario, because done only clears on reset. The disturbance scenario flips both straps and pulses start_i while a run is in flight, so the expected command list and the expected final values must still come from the strap values held at start.

// File: rtl/ddr_pu_pkg.sv
package ddr_pu_pkg;

  localparam int CMD_W   = 6;
  localparam int SEL_W   = 2;
  localparam int MDATA_W = 13;
  localparam int IDX_W   = 4;

  localparam int DDR2_STEPS = 11;
  localparam int DDR1_STEPS = 5;

  // command code bit positions (decoded by the command PHY)
  localparam int CB_LOAD_MR   = 0;
  localparam int CB_LOAD_EMR  = 1;
  localparam int CB_AREF      = 2;
  localparam int CB_PREA      = 3;
  localparam int CB_LOAD_EMR2 = 4;
  localparam int CB_LOAD_EMR3 = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_MR   = 2'd0,
    SEL_EMR  = 2'd1,
    SEL_EMR2 = 2'd2,
    SEL_EMR3 = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_GAP   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [CMD_W-1:0]   code;
    reg_sel_e           sel;
    logic [MDATA_W-1:0] data;
  } step_t;

  function automatic step_t mk_plain(input int bitpos);
    step_t s;
    s.code = '0;
    s.code[bitpos] = 1'b1;
    s.sel  = SEL_MR;
    s.data = '0;
    return s;
  endfunction

  function automatic step_t mk_load(input reg_sel_e sel, input logic [MDATA_W-1:0] value);
    step_t s;
    s.code = '0;
    case (sel)
      SEL_MR:   s.code[CB_LOAD_MR]   = 1'b1;
      SEL_EMR:  s.code[CB_LOAD_EMR]  = 1'b1;
      SEL_EMR2: s.code[CB_LOAD_EMR2] = 1'b1;
      default:  s.code[CB_LOAD_EMR3] = 1'b1;
    endcase
    s.sel  = sel;
    s.data = value;
    return s;
  endfunction

endpackage

// File: rtl/ddr_pu_step_rom.sv
module ddr_pu_step_rom
  import ddr_pu_pkg::*;
(
  input  logic             is_ddr2_i,
  input  logic [IDX_W-1:0] idx_i,
  output step_t            step_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] LAST2 = IDX_W'(DDR2_STEPS - 1);
  localparam logic [IDX_W-1:0] LAST1 = IDX_W'(DDR1_STEPS - 1);

  step_t s2, s1;

  always_comb begin
    case (idx_i)
      4'd0:    s2 = mk_plain(CB_PREA);
      4'd1:    s2 = mk_load(SEL_EMR2, 13'h000);
      4'd2:    s2 = mk_load(SEL_EMR3, 13'h000);
      4'd3:    s2 = mk_load(SEL_EMR,  13'h000);
      4'd4:    s2 = mk_load(SEL_MR,   13'h100);
      4'd5:    s2 = mk_plain(CB_PREA);
      4'd6:    s2 = mk_plain(CB_AREF);
      4'd7:    s2 = mk_plain(CB_AREF);
      4'd8:    s2 = mk_load(SEL_MR,   13'hA33);
      4'd9:    s2 = mk_load(SEL_EMR,  13'h382);
      4'd10:   s2 = mk_load(SEL_EMR,  13'h402);
      default: s2 = '0;
    endcase
  end

  always_comb begin
    case (idx_i)
      4'd0:    s1 = mk_plain(CB_PREA);
      4'd1:    s1 = mk_load(SEL_MR,  13'h133);
      4'd2:    s1 = mk_load(SEL_EMR, 13'h002);
      4'd3:    s1 = mk_plain(CB_PREA);
      4'd4:    s1 = mk_load(SEL_MR,  13'h033);
      default: s1 = '0;
    endcase
  end

  always_comb begin
    step_o = is_ddr2_i ? s2 : s1;
    last_o = is_ddr2_i ? (idx_i >= LAST2) : (idx_i >= LAST1);
  end

endmodule

// File: rtl/ddr_pu_gap_timer.sv
module ddr_pu_gap_timer #(
  parameter int GAP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? RELOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_pu_final_regs.sv
module ddr_pu_final_regs #(
  parameter int CFG_W      = 16,
  parameter int REF_W      = 16,
  parameter int TAP_W      = 6,
  parameter int MASK_W     = 8,
  parameter int WR_LAT     = 2,
  parameter int FAW_CYC    = 22,
  parameter int REF_CNT_40 = 624,
  parameter int REF_CNT_25 = 390,
  parameter int TAP0_INIT  = 8,
  parameter int TAP1_INIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic              cfg_ddr2_i,
  input  logic              fin_load_i,
  input  logic              ref40_i,
  output logic [CFG_W-1:0]  ddr2_cfg_o,
  output logic [REF_W-1:0]  refresh_o,
  output logic [TAP_W-1:0]  tap0_o,
  output logic [TAP_W-1:0]  tap1_o,
  output logic [MASK_W-1:0] rd_mask_o
);

  localparam logic [15:0] CFG_WORD = {2'b00, 4'(WR_LAT), 1'b1, 1'b0, 6'(FAW_CYC), 1'b0, 1'b1};
  localparam logic [15:0] REF_40   = {1'b0, 1'b1, 4'b0000, 10'(REF_CNT_40)};
  localparam logic [15:0] REF_25   = {1'b0, 1'b1, 4'b0000, 10'(REF_CNT_25)};

  logic [CFG_W-1:0] cfg_d;
  logic [REF_W-1:0] ref_d;

  always_comb begin
    cfg_d = cfg_ddr2_i ? CFG_W'(CFG_WORD) : '0;
    ref_d = ref40_i ? REF_W'(REF_40) : REF_W'(REF_25);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ddr2_cfg_o <= '0;
    else if (cfg_load_i) ddr2_cfg_o <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refresh_o <= '0;
      tap0_o    <= '0;
      tap1_o    <= '0;
      rd_mask_o <= '0;
    end else if (fin_load_i) begin
      refresh_o <= ref_d;
      tap0_o    <= TAP_W'(TAP0_INIT);
      tap1_o    <= TAP_W'(TAP1_INIT);
      rd_mask_o <= '1;
    end
  end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
  import ddr_pu_pkg::*;
#(
  parameter int GAP_CYCLES = 8,
  parameter int CFG_W      = 16,
  parameter int REF_W      = 16,
  parameter int TAP_W      = 6,
  parameter int MASK_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               strap_ddr2_i,
  input  logic               strap_ref40_i,
  output logic               cmd_valid_o,
  output logic [CMD_W-1:0]   cmd_code_o,
  output logic [SEL_W-1:0]   reg_sel_o,
  output logic [MDATA_W-1:0] mode_data_o,
  output logic [CFG_W-1:0]   ddr2_cfg_o,
  output logic [REF_W-1:0]   refresh_o,
  output logic [TAP_W-1:0]   dqs_tap0_o,
  output logic [TAP_W-1:0]   dqs_tap1_o,
  output logic [MASK_W-1:0]  rd_mask_o,
  output logic               busy_o,
  output logic               done_o
);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             ddr2_q, ref40_q;
  logic             accept;
  logic             gap_expired, gap_load;
  logic             last_step, finish;
  step_t            cur_step;

  ddr_pu_step_rom u_rom (
    .is_ddr2_i (ddr2_q),
    .idx_i     (idx_q),
    .step_o    (cur_step),
    .last_o    (last_step)
  );

  ddr_pu_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (gap_load),
    .expired_o (gap_expired)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    accept   = 1'b0;
    gap_load = 1'b0;
    finish   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept  = 1'b1;
          state_d = ST_ISSUE;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_ISSUE: begin
        gap_load = 1'b1;
        state_d  = ST_GAP;
      end
      ST_GAP: begin
        if (gap_expired) begin
          if (last_step) begin
            finish  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_ISSUE;
            idx_d   = idx_q + 1'b1;
            idx_en  = 1'b1;
          end
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // straps captured only when a start is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr2_q  <= 1'b0;
      ref40_q <= 1'b0;
    end else if (accept) begin
      ddr2_q  <= strap_ddr2_i;
      ref40_q <= strap_ref40_i;
    end
  end

  ddr_pu_final_regs #(
    .CFG_W  (CFG_W),
    .REF_W  (REF_W),
    .TAP_W  (TAP_W),
    .MASK_W (MASK_W)
  ) u_fin (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load_i (accept),
    .cfg_ddr2_i (strap_ddr2_i),
    .fin_load_i (finish),
    .ref40_i    (ref40_q),
    .ddr2_cfg_o (ddr2_cfg_o),
    .refresh_o  (refresh_o),
    .tap0_o     (dqs_tap0_o),
    .tap1_o     (dqs_tap1_o),
    .rd_mask_o  (rd_mask_o)
  );

  // outputs decoded from registered state
  always_comb begin
    cmd_valid_o = (state_q == ST_ISSUE);
    cmd_code_o  = cmd_valid_o ? cur_step.code : '0;
    reg_sel_o   = cmd_valid_o ? cur_step.sel  : '0;
    mode_data_o = cmd_valid_o ? cur_step.data : '0;
    busy_o      = (state_q == ST_ISSUE) || (state_q == ST_GAP);
    done_o      = (state_q == ST_DONE);
  end

endmodule

// File: rtl/ddr_pu_checker.sv
module ddr_pu_checker #(
  parameter int GAP_CYCLES = 8,
  parameter int CFG_W      = 16,
  parameter int REF_W      = 16,
  parameter int TAP_W      = 6,
  parameter int MASK_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_o,
  input logic [5:0]        cmd_code_o,
  input logic [1:0]        reg_sel_o,
  input logic [12:0]       mode_data_o,
  input logic [CFG_W-1:0]  ddr2_cfg_o,
  input logic [REF_W-1:0]  refresh_o,
  input logic [TAP_W-1:0]  dqs_tap0_o,
  input logic [TAP_W-1:0]  dqs_tap1_o,
  input logic [MASK_W-1:0] rd_mask_o,
  input logic              busy_o,
  input logic              done_o
);

  localparam int GW = $clog2(GAP_CYCLES + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (cmd_valid_o) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != GMAX) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && seen_q) |-> (since_q == GW'(GAP_CYCLES)));

  assert_quiet_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_o |-> (cmd_code_o == '0 && reg_sel_o == '0 && mode_data_o == '0));

  assert_code_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ($countones(cmd_code_o) == 1));

  assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> busy_o);

  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ddr2_cfg_o));

  assert_refresh_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (refresh_o == REF_W'(16'h4270) || refresh_o == REF_W'(16'h4186)));

  assert_final_values_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (dqs_tap0_o == TAP_W'(8) && dqs_tap1_o == TAP_W'(9) && rd_mask_o == '1));

  assert_pre_done_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (refresh_o == '0 && dqs_tap0_o == '0 && dqs_tap1_o == '0 && rd_mask_o == '0));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cmd_valid_o && !busy_o));

endmodule

bind ddr_powerup_seq ddr_pu_checker #(
  .GAP_CYCLES (GAP_CYCLES),
  .CFG_W      (CFG_W),
  .REF_W      (REF_W),
  .TAP_W      (TAP_W),
  .MASK_W     (MASK_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_o (cmd_valid_o),
  .cmd_code_o  (cmd_code_o),
  .reg_sel_o   (reg_sel_o),
  .mode_data_o (mode_data_o),
  .ddr2_cfg_o  (ddr2_cfg_o),
  .refresh_o   (refresh_o),
  .dqs_tap0_o  (dqs_tap0_o),
  .dqs_tap1_o  (dqs_tap1_o),
  .rd_mask_o   (rd_mask_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/tb_ddr_powerup_seq.sv
`timescale 1ns/1ps
module tb_ddr_powerup_seq;

  localparam int G = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, strap_ddr2_i, strap_ref40_i;
  logic        cmd_valid_o;
  logic [5:0]  cmd_code_o;
  logic [1:0]  reg_sel_o;
  logic [12:0] mode_data_o;
  logic [15:0] ddr2_cfg_o, refresh_o;
  logic [5:0]  dqs_tap0_o, dqs_tap1_o;
  logic [7:0]  rd_mask_o;
  logic        busy_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ddr_powerup_seq #(.GAP_CYCLES(G)) dut (
    .clk, .rst_n, .start_i, .strap_ddr2_i, .strap_ref40_i,
    .cmd_valid_o, .cmd_code_o, .reg_sel_o, .mode_data_o,
    .ddr2_cfg_o, .refresh_o, .dqs_tap0_o, .dqs_tap1_o, .rd_mask_o,
    .busy_o, .done_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // expected command list, built from R4/R5/R6
  task automatic exp_step(input bit d2, input int k, output logic [5:0] code,
                          output logic [1:0] sel, output logic [12:0] data);
    code = 6'h08; sel = 2'd0; data = 13'h0;
    if (d2) begin
      case (k)
        0, 5: begin code = 6'h08; end
        1:    begin code = 6'h10; sel = 2'd2; data = 13'h000; end
        2:    begin code = 6'h20; sel = 2'd3; data = 13'h000; end
        3:    begin code = 6'h02; sel = 2'd1; data = 13'h000; end
        4:    begin code = 6'h01; sel = 2'd0; data = 13'h100; end
        6, 7: begin code = 6'h04; end
        8:    begin code = 6'h01; sel = 2'd0; data = 13'hA33; end
        9:    begin code = 6'h02; sel = 2'd1; data = 13'h382; end
        default: begin code = 6'h02; sel = 2'd1; data = 13'h402; end
      endcase
    end else begin
      case (k)
        0, 3: begin code = 6'h08; end
        1:    begin code = 6'h01; sel = 2'd0; data = 13'h133; end
        2:    begin code = 6'h02; sel = 2'd1; data = 13'h002; end
        default: begin code = 6'h01; sel = 2'd0; data = 13'h033; end
      endcase
    end
  endtask

  task automatic do_reset_check();
    start_i = 1'b0; strap_ddr2_i = 1'b0; strap_ref40_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({cmd_valid_o, cmd_code_o, reg_sel_o, mode_data_o, ddr2_cfg_o, refresh_o,
           dqs_tap0_o, dqs_tap1_o, rd_mask_o, busy_o, done_o} == '0,
          "R1", "outputs in reset", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cmd_valid_o, ddr2_cfg_o, refresh_o, rd_mask_o, busy_o, done_o} == '0,
          "R1", "outputs after release", {busy_o, done_o}, 0);
  endtask

  task automatic run_seq(input bit d2, input bit r40, input bit disturb, input bit restart_after);
    int n = d2 ? 11 : 5;
    int quiet_bad = 0, done_bad = 0, pre_bad = 0, strap_seen = 0;
    logic [5:0] ec; logic [1:0] es; logic [12:0] ed;
    do_reset_check();
    strap_ddr2_i = d2; strap_ref40_i = r40; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 1; cyc <= n*(G+1) + 3; cyc++) begin
      if (cyc > 1) @(negedge clk);
      if (disturb && cyc == 5)  begin strap_ddr2_i = ~d2; strap_ref40_i = ~r40; start_i = 1'b1; end
      if (disturb && cyc == 6)  start_i = 1'b0;
      if (disturb && cyc == 30) start_i = 1'b1;
      if (disturb && cyc == 31) start_i = 1'b0;
      if (cyc == 1) begin
        check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        check(ddr2_cfg_o == (d2 ? 16'hA59 : 16'h0), "R7", "ddr2 config word", ddr2_cfg_o, d2 ? 16'hA59 : 0);
      end
      if (((cyc-1) % (G+1)) == 0 && (cyc-1)/(G+1) < n) begin
        int k = (cyc-1)/(G+1);
        exp_step(d2, k, ec, es, ed);
        check(cmd_valid_o == 1'b1, d2 ? "R5" : "R6", $sformatf("strobe %0d (R2 R3)", k), cmd_valid_o, 1);
        check(cmd_code_o == ec, "R4", $sformatf("code of step %0d", k), cmd_code_o, ec);
        check(reg_sel_o == es && mode_data_o == ed, d2 ? "R5" : "R6",
              $sformatf("sel/data of step %0d", k), {reg_sel_o, mode_data_o}, {es, ed});
      end else if (cmd_valid_o || cmd_code_o != 0 || reg_sel_o != 0 || mode_data_o != 0) begin
        quiet_bad++;
      end
      if (done_o != (cyc >= 1 + n*(G+1)) || busy_o != (cyc < 1 + n*(G+1))) done_bad++;
      if (cyc < 1 + n*(G+1) && (refresh_o != 0 || dqs_tap0_o != 0 || dqs_tap1_o != 0 || rd_mask_o != 0))
        pre_bad++;
      if (disturb && ddr2_cfg_o != (d2 ? 16'hA59 : 16'h0)) strap_seen++;
    end
    check(quiet_bad == 0, "R3", "no strobe/fields outside command slots", quiet_bad, 0);
    check(done_bad == 0, "R10", "done/busy timing", done_bad, 0);
    check(pre_bad == 0, "R9", "final values zero before done", pre_bad, 0);
    check(refresh_o == (r40 ? 16'h4270 : 16'h4186), "R8", "refresh word", refresh_o, r40 ? 16'h4270 : 16'h4186);
    check(dqs_tap0_o == 6'h08 && dqs_tap1_o == 6'h09 && rd_mask_o == 8'hFF, "R9", "taps and mask",
          {dqs_tap0_o, dqs_tap1_o, rd_mask_o}, {6'h08, 6'h09, 8'hFF});
    if (disturb) begin
      check(strap_seen == 0, "R12", "config unaffected by strap flip", strap_seen, 0);
      check(1'b1 && quiet_bad == 0 && done_bad == 0, "R11", "mid-run start ignored", quiet_bad + done_bad, 0);
    end
    if (restart_after) begin
      int extra = 0;
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      repeat (3*(G+1)) begin
        @(negedge clk);
        if (cmd_valid_o || busy_o || !done_o) extra++;
      end
      check(extra == 0, "R11", "start after done ignored", extra, 0);
      check(done_o == 1'b1, "R10", "done sticky", done_o, 1);
    end
  endtask

  task automatic t_reset();      do_reset_check(); endtask
  task automatic t_ddr2_40();    run_seq(1'b1, 1'b1, 1'b0, 1'b0); endtask
  task automatic t_ddr2_25_dis(); run_seq(1'b1, 1'b0, 1'b1, 1'b0); endtask
  task automatic t_ddr1_25();    run_seq(1'b0, 1'b0, 1'b0, 1'b1); endtask
  task automatic t_ddr1_40_dis(); run_seq(1'b0, 1'b1, 1'b1, 1'b1); endtask

  initial begin
    t_reset();
    t_ddr2_40();
    t_ddr2_25_dis();
    t_ddr1_25();
    t_ddr1_40_dis();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule